// File: doc/BRIEF.md
# Vector Multishift Byte Extraction Unit

This unit carries out a byte-granular bit-field extraction across a vector of 64-bit lanes. Each lane has a control qword and a data qword. Every byte of the control qword picks a starting bit inside the data qword. The matching result byte is the eight bits found from that start upward, wrapping from bit 63 back to bit 0. Put another way, the result byte is the low byte of the data qword after it is rotated right by the chosen offset.

The lane results then pass through a write gate. A vector-length code sets how many lanes are live, and lanes above that count always come out as zero. In the masked form, a per-lane opmask decides whether a live lane takes its computed qword. A lane whose opmask bit is clear either keeps the old destination qword or is cleared, according to a zero-masking flag. The full-width result is registered once. `out_valid` marks the cycle in which it is ready.

A two-state output sequencer sets the handshake. State `ST_IDLE` means no result is being presented, and `ST_OUT` means `result` holds a fresh value. The transition *accept* (`in_valid` high) moves to `ST_OUT` from either state, or stays there. The transition *drain* (`in_valid` low) returns to `ST_IDLE`. A synchronous reset forces `ST_IDLE`.

Top module: `vmshift_unit`

## Requirements
- R1: Output byte n of lane k (bits [64k+8n+7 : 64k+8n]) is taken from data qword k with offset equal to bits [5:0] of control byte n of lane k. Its bit b equals data bit (offset+b) mod 64.
- R2: Bits [7:6] of every control byte have no effect on the result.
- R3: An offset of 0 yields bits [7:0] of the data qword unchanged.
- R4: Each lane uses only its own control qword and data qword, so changing other lanes leaves it unaltered.
- R5: `vlen_code` 0 activates lanes 0..1, 1 activates lanes 0..3, and 2 or 3 activates lanes 0..7. Every inactive lane's qword is zero.
- R6: With `masked_en`=1, an active lane whose `lane_mask` bit k is 1 receives its computed qword.
- R7: With `masked_en`=1 and `zero_mask`=0, an active lane whose `lane_mask` bit is 0 keeps its `dest_vec` qword.
- R8: With `masked_en`=1 and `zero_mask`=1, an active lane whose `lane_mask` bit is 0 becomes zero.
- R9: With `masked_en`=0, `lane_mask` and `zero_mask` have no effect, and every active lane receives its computed qword.
- R10: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and in that cycle `result` holds the value for that input.
- R11: A synchronous active-high `rst` forces `out_valid` low on the following cycle, including when `in_valid` is high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| ctrl_vec | input | 512 | Control vector, one offset byte per output byte |
| data_vec | input | 512 | Data vector, one source qword per lane |
| dest_vec | input | 512 | Old destination vector used for merging |
| lane_mask | input | 8 | Per-lane opmask, bit k gates lane k |
| masked_en | input | 1 | 1 selects the masked form |
| zero_mask | input | 1 | 1 clears unselected lanes instead of merging |
| vlen_code | input | 2 | Vector length: 0=128, 1=256, 2 or 3=512 bits |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered result vector |

## Verification
Offsets 0, 57 and 63 are driven directly. They separate a correct wrap from a plain shift, which would lose the top bits, and from an off-by-one rotation. The same offsets are then driven with bits 7:6 of the control bytes set, which shows whether those bits leak into the offset. Lanes that share a control qword but hold different data show whether lanes are crossed. Each vector-length code, together with all-clear, alternating and all-set opmasks under merge, zero and unmasked forms, separates length clearing from masking. Several hundred random operand sets, sent back to back and with gaps, are compared lane by lane with a bit-by-bit rotation model. These runs cover the valid timing and the ordering of results.

// File: rtl/vmshift_pkg.sv
package vmshift_pkg;

    localparam int LANE_W    = 64;
    localparam int BYTE_W    = 8;
    localparam int NUM_LANES = 8;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } ostate_e;

endpackage

// File: rtl/vmshift_window.sv
module vmshift_window #(
    parameter int LANE_W = 64,
    parameter int BYTE_W = 8,
    localparam int OFS_W = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    output logic [BYTE_W-1:0] win_o
);

    logic [OFS_W-1:0] ofs;
    logic             unused_hi;

    assign ofs       = ctrl_i[OFS_W-1:0];
    assign unused_hi = ^ctrl_i[BYTE_W-1:OFS_W];

    always_comb begin
        for (int b = 0; b < BYTE_W; b++) begin
            win_o[b] = data_i[OFS_W'(ofs + OFS_W'(b))];
        end
    end

    // R3
    always_comb begin
        if (ofs == '0) begin
            ofs_zero_chk: assert (win_o == data_i[BYTE_W-1:0]);
        end
    end

endmodule

// File: rtl/vmshift_lane.sv
module vmshift_lane #(
    parameter int LANE_W = 64,
    parameter int BYTE_W = 8,
    localparam int NBYTES = LANE_W / BYTE_W
) (
    input  logic [LANE_W-1:0] ctrl_q,
    input  logic [LANE_W-1:0] data_q,
    input  logic [LANE_W-1:0] dest_q,
    input  logic              active_i,
    input  logic              write_i,
    input  logic              zero_i,
    output logic [LANE_W-1:0] res_q
);

    logic [LANE_W-1:0] calc_q;

    for (genvar n = 0; n < NBYTES; n++) begin : g_byte
        vmshift_window #(
            .LANE_W(LANE_W),
            .BYTE_W(BYTE_W)
        ) u_win (
            .data_i(data_q),
            .ctrl_i(ctrl_q[n*BYTE_W +: BYTE_W]),
            .win_o (calc_q[n*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        if (!active_i) begin
            res_q = '0;
        end else if (write_i) begin
            res_q = calc_q;
        end else if (zero_i) begin
            res_q = '0;
        end else begin
            res_q = dest_q;
        end
    end

endmodule

// File: rtl/vmshift_unit.sv
module vmshift_unit
    import vmshift_pkg::*;
#(
    parameter int NUM_LN  = NUM_LANES,
    parameter int LN_W    = LANE_W,
    parameter int BY_W    = BYTE_W,
    localparam int VEC_W  = NUM_LN * LN_W,
    localparam int CNT_W  = $clog2(NUM_LN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  ctrl_vec,
    input  logic [VEC_W-1:0]  data_vec,
    input  logic [VEC_W-1:0]  dest_vec,
    input  logic [NUM_LN-1:0] lane_mask,
    input  logic              masked_en,
    input  logic              zero_mask,
    input  logic [1:0]        vlen_code,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);

    ostate_e          state_q, state_d;
    logic [CNT_W-1:0] act_lanes;
    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] result_q;

    always_comb begin
        unique case (vlen_e'(vlen_code))
            VL_128:  act_lanes = CNT_W'(NUM_LN / 4);
            VL_256:  act_lanes = CNT_W'(NUM_LN / 2);
            VL_512:  act_lanes = CNT_W'(NUM_LN);
            VL_RSVD: act_lanes = CNT_W'(NUM_LN);
        endcase
    end

    for (genvar k = 0; k < NUM_LN; k++) begin : g_lane
        vmshift_lane #(
            .LANE_W(LN_W),
            .BYTE_W(BY_W)
        ) u_lane (
            .ctrl_q  (ctrl_vec[k*LN_W +: LN_W]),
            .data_q  (data_vec[k*LN_W +: LN_W]),
            .dest_q  (dest_vec[k*LN_W +: LN_W]),
            .active_i(act_lanes > CNT_W'(k)),
            .write_i (!masked_en || lane_mask[k]),
            .zero_i  (zero_mask),
            .res_q   (lane_res[k*LN_W +: LN_W])
        );
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= lane_res;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_OUT);
        result    = result_q;
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5
    len_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_code == 2'd0) |=> (result[VEC_W-1:VEC_W/4] == '0));

    // R8
    zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && masked_en && zero_mask && !lane_mask[0])
        |=> (result[LN_W-1:0] == '0));

    // R7
    merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && masked_en && !zero_mask && !lane_mask[0])
        |=> (result[LN_W-1:0] == $past(dest_vec[LN_W-1:0])));

endmodule

// File: tb/vmshift_unit_bench.sv
module vmshift_unit_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [511:0] ctrl_vec, data_vec, dest_vec;
    logic [7:0]   lane_mask;
    logic         masked_en, zero_mask;
    logic [1:0]   vlen_code;
    logic         out_valid;
    logic [511:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [511:0] exp_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    vmshift_unit u_vmshift_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ctrl_vec(ctrl_vec), .data_vec(data_vec), .dest_vec(dest_vec),
        .lane_mask(lane_mask), .masked_en(masked_en), .zero_mask(zero_mask),
        .vlen_code(vlen_code), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] ref_lane(input logic [63:0] c, input logic [63:0] d);
        logic [63:0] r;
        logic [63:0] out;
        int off;
        out = '0;
        for (int n = 0; n < 8; n++) begin
            off = int'(c[n*8 +: 6]);
            r = d;
            for (int s = 0; s < off; s++) r = {r[0], r[63:1]};
            out[n*8 +: 8] = r[7:0];
        end
        return out;
    endfunction

    function automatic logic [511:0] ref_vec(
        input logic [511:0] c, input logic [511:0] d, input logic [511:0] o,
        input logic [7:0] m, input logic me, input logic zm, input logic [1:0] vl);
        logic [511:0] v;
        int act;
        act = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        for (int k = 0; k < 8; k++) begin
            if (k >= act)            v[k*64 +: 64] = '0;
            else if (!me || m[k])    v[k*64 +: 64] = ref_lane(c[k*64 +: 64], d[k*64 +: 64]);
            else if (zm)             v[k*64 +: 64] = '0;
            else                     v[k*64 +: 64] = o[k*64 +: 64];
        end
        return v;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic send(input logic [511:0] c, input logic [511:0] d, input logic [511:0] o,
                        input logic [7:0] m, input logic me, input logic zm,
                        input logic [1:0] vl, input string tag);
        @(negedge clk);
        ctrl_vec = c; data_vec = d; dest_vec = o; lane_mask = m;
        masked_en = me; zero_mask = zm; vlen_code = vl; in_valid = 1'b1;
        exp_q.push_back(ref_vec(c, d, o, m, me, zm, vl));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check1(input bit ok, input string tag, input logic [511:0] act,
                          input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check1(1'b0, "R10 unexpected out_valid", 512'd1, 512'd0);
            end else begin
                logic [511:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int k = 0; k < 8; k++) begin
                    checks++;
                    if (result[k*64 +: 64] !== e[k*64 +: 64]) begin
                        errors++;
                        $display("FAIL %s lane %0d: got %h expected %h",
                                 t, k, result[k*64 +: 64], e[k*64 +: 64]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog expired: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [511:0] c, d, o, c_hi;
        rst = 1'b1; in_valid = 1'b0; ctrl_vec = '0; data_vec = '0; dest_vec = '0;
        lane_mask = '0; masked_en = 1'b0; zero_mask = 1'b0; vlen_code = 2'd2;
        repeat (3) @(negedge clk);
        check1(out_valid == 1'b0, "R11 reset state", {511'd0, out_valid}, 512'd0);
        rst = 1'b0;

        // R3, R1: offsets 0, 57, 63 across lanes
        d = rnd512();
        c = '0;
        for (int k = 0; k < 8; k++)
            c[k*64 +: 64] = {8'd63, 8'd57, 8'd0, 8'd1, 8'd7, 8'd56, 8'd63, 8'd0};
        send(c, d, rnd512(), 8'hFF, 1'b0, 1'b0, 2'd2, "R1/R3 directed offsets");
        c_hi = c;
        for (int b = 0; b < 64; b++) c_hi[b*8 +: 8] = c[b*8 +: 8] | 8'hC0;
        send(c_hi, d, rnd512(), 8'hFF, 1'b0, 1'b0, 2'd2, "R2 upper control bits");
        send(512'd0, d, '0, 8'hFF, 1'b0, 1'b0, 2'd2, "R3 all offsets zero");
        idle(2);
        check1(out_valid == 1'b0, "R10 idle after drain", {511'd0, out_valid}, 512'd0);

        // R4: same control, distinct data per lane
        c = '0;
        for (int k = 0; k < 8; k++) c[k*64 +: 64] = 64'h3F39_2A11_0804_0201;
        send(c, rnd512(), '0, 8'hFF, 1'b0, 1'b0, 2'd2, "R4 lane independence");

        // R5: every length code
        for (int vl = 0; vl < 4; vl++)
            send(rnd512(), rnd512(), rnd512(), 8'hFF, 1'b1, 1'b0, 2'(vl), "R5 vector length");

        // R6/R7/R8/R9 masks
        o = rnd512();
        send(rnd512(), rnd512(), o, 8'hFF, 1'b1, 1'b0, 2'd2, "R6 all lanes written");
        send(rnd512(), rnd512(), o, 8'h00, 1'b1, 1'b0, 2'd2, "R7 merge all kept");
        send(rnd512(), rnd512(), o, 8'h5A, 1'b1, 1'b0, 2'd3, "R7 merge alternating");
        send(rnd512(), rnd512(), o, 8'h00, 1'b1, 1'b1, 2'd2, "R8 zero all cleared");
        send(rnd512(), rnd512(), o, 8'hA5, 1'b1, 1'b1, 2'd1, "R8 zero alternating");
        send(rnd512(), rnd512(), o, 8'h00, 1'b0, 1'b1, 2'd2, "R9 unmasked ignores mask");
        idle(1);

        // R11: reset concurrent with in_valid
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check1(out_valid == 1'b0, "R11 reset beats in_valid", {511'd0, out_valid}, 512'd0);
        rst = 1'b0; in_valid = 1'b0;
        idle(1);

        // random stream with gaps (R1, R10)
        for (int i = 0; i < 300; i++) begin
            send(rnd512(), rnd512(), rnd512(), 8'($urandom), 1'($urandom),
                 1'($urandom), 2'($urandom), "R1/R10 random");
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
        end
        idle(3);
        check1(exp_q.size() == 0, "R10 all results delivered",
               512'(exp_q.size()), 512'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule